// File: doc/BRIEF.md
# Write-Protection Command Sequence Guard

This block sits between the write cycles reaching a nonvolatile memory and the logic that loads its page buffer. It decides, one write strobe at a time, whether that write may go on to the page-load logic. It also watches the write stream for two command sequences. Each command is a series of writes with fixed address and data values, issued back to back. A three-write lock command turns protection on and opens a window for exactly one page load. A six-write release command turns protection off once a write-cycle interval has passed.

While protection is off, every write goes straight through, and that includes writes that happen to match command steps. While protection is on, a write reaches the array only inside the window that a lock command opened. The window closes on the page-load-complete pulse. Command writes seen while protected are swallowed and flagged as consumed. Any other write is blocked. A command sequence must be continuous. The next step has to arrive within a gap limit of `GAP_CYC` cycles, and any write that does not fit the sequence sends the matcher back to its start.

The state machine has eight states:
- `ST_IDLE`: no sequence in progress.
- `ST_K1`: lead step seen.
- `ST_K2`: second step seen.
- `ST_K3`: erase step seen.
- `ST_K4`: lead step seen again.
- `ST_K5`: second step seen again.
- `ST_OPEN`: page window open.
- `ST_DRAIN`: release write cycle running.

It has these transitions:
- lead: `ST_IDLE`→`ST_K1`.
- second: `ST_K1`→`ST_K2`.
- lock: `ST_K2`→`ST_OPEN`.
- erase: `ST_K2`→`ST_K3`.
- relead: `ST_K3`→`ST_K4`.
- resecond: `ST_K4`→`ST_K5`.
- clear: `ST_K5`→`ST_DRAIN`.
- break: `ST_K1`..`ST_K5` go to `ST_K1` on a lead-step write, otherwise to `ST_IDLE`.
- timeout: `ST_K1`..`ST_K5`→`ST_IDLE`.
- close: `ST_OPEN`→`ST_IDLE` on the page-load-complete pulse.
- drain end: `ST_DRAIN`→`ST_IDLE`, with protection cleared.

Top module: `wprot_seq_guard`

## Requirements
- R1: After reset `prot_on` equals parameter `PROT_INIT` (default 0), the matcher is idle, and `wr_pass` and `cmd_eat` are 0 in every cycle where `wr_stb` is 0.
- R2: While `prot_on` is 0 and no release is draining, every write raises `wr_pass` combinationally in its own strobe cycle and `cmd_eat` stays 0, including writes that match command steps.
- R3: The lock command is three consecutive writes: data 0xAA to address 0x5555, data 0x55 to address 0x2AAA, and data 0xA0 to address 0x5555. After the edge that samples the third write, `prot_on` is 1. While `prot_on` is 1, each command-step write gives `cmd_eat`=1 and `wr_pass`=0.
- R4: After a lock command the page window is open. Every write in it gives `wr_pass`=1 until a `load_done` pulse. A write in the same cycle as `load_done` is still forwarded. Writes after that cycle are blocked again.
- R5: With `prot_on`=1 and no window open, a write that is not a command step gives `wr_pass`=0 and `cmd_eat`=0.
- R6: The release command is six consecutive writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. `prot_on` stays 1 for `WC_CYC`-1 edges after the edge that samples the sixth write, and reads 0 after `WC_CYC` edges. Writes during that interval give `wr_pass`=0 and `cmd_eat`=0.
- R7: A write that does not fit a sequence in progress returns the matcher to idle. If that write is 0xAA@0x5555, it is taken as the first step of a new sequence instead.
- R8: The next step must be sampled no later than `GAP_CYC` edges after the previous step. If it comes later, the sequence is abandoned and that write is judged from idle.
- R9: `load_done` has no effect outside an open page window.
- R10: The step after 0x55@0x2AAA is chosen by its data byte: 0xA0 completes the lock command and 0x80 continues toward the release command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data |
| load_done | input | 1 | Page load and its write cycle finished |
| wr_pass | output | 1 | Write may go to the page-load logic (combinational) |
| cmd_eat | output | 1 | Write was consumed as a command step (combinational) |
| prot_on | output | 1 | Protection enabled |

## Verification
The page-load-complete pulse and a data write can fall in the same cycle while the window is open. The bench drives both in one strobe cycle and expects that write to pass. The next write must then be blocked. A second collision comes from a write that arrives in the cycle the release interval would otherwise run on. That write must be dropped, and protection must still fall on the edge counted from the sixth command write.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_K3,
        ST_K4,
        ST_K5,
        ST_OPEN,
        ST_DRAIN
    } seq_state_e;

endpackage

// File: rtl/wprot_key_match.sv
module wprot_key_match #(
    parameter int              AW          = 15,
    parameter int              DW          = 8,
    parameter logic [AW-1:0]   KEY_A_ADDR  = 15'h5555,
    parameter logic [AW-1:0]   KEY_B_ADDR  = 15'h2AAA,
    parameter logic [DW-1:0]   CODE_LEAD   = 8'hAA,
    parameter logic [DW-1:0]   CODE_SECOND = 8'h55,
    parameter logic [DW-1:0]   CODE_LOCK   = 8'hA0,
    parameter logic [DW-1:0]   CODE_ERASE  = 8'h80,
    parameter logic [DW-1:0]   CODE_CLEAR  = 8'h20
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          hit_lead,
    output logic          hit_second,
    output logic          hit_lock,
    output logic          hit_erase,
    output logic          hit_clear
);

    logic at_a;
    logic at_b;

    // Address decode first, then pair each key address with its data code.
    always_comb begin
        at_a       = (addr == KEY_A_ADDR);
        at_b       = (addr == KEY_B_ADDR);
        hit_lead   = at_a && (data == CODE_LEAD);
        hit_second = at_b && (data == CODE_SECOND);
        hit_lock   = at_a && (data == CODE_LOCK);
        hit_erase  = at_a && (data == CODE_ERASE);
        hit_clear  = at_a && (data == CODE_CLEAR);
    end

endmodule

// File: rtl/wprot_tick_timer.sv
module wprot_tick_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic done
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // done marks the cycle in which the interval ends; the count then holds.
    always_comb begin
        done = run && (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wprot_seq_guard.sv
module wprot_seq_guard
    import wprot_pkg::*;
#(
    parameter int   ADDR_W    = 15,
    parameter int   DATA_W    = 8,
    parameter int   GAP_CYC   = 16,
    parameter int   WC_CYC    = 24,
    parameter logic PROT_INIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_done,
    output logic              wr_pass,
    output logic              cmd_eat,
    output logic              prot_on
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       prot_q;
    logic       prot_set;
    logic       prot_clr;
    logic       step_hit;
    logic       hunting;
    logic       in_seq;
    logic       gap_done;
    logic       wc_done;
    logic       hit_lead;
    logic       hit_second;
    logic       hit_lock;
    logic       hit_erase;
    logic       hit_clear;

    wprot_key_match #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_keys (
        .addr       (wr_addr),
        .data       (wr_data),
        .hit_lead   (hit_lead),
        .hit_second (hit_second),
        .hit_lock   (hit_lock),
        .hit_erase  (hit_erase),
        .hit_clear  (hit_clear)
    );

    // hunting: the matcher judges writes (idle or mid-sequence).
    // in_seq: a partial sequence is waiting for its next step.
    always_comb begin
        hunting = (state_q != ST_OPEN) && (state_q != ST_DRAIN);
        in_seq  = hunting && (state_q != ST_IDLE);
    end

    wprot_tick_timer #(
        .LIMIT (GAP_CYC)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_stb || !in_seq),
        .run   (in_seq),
        .done  (gap_done)
    );

    wprot_tick_timer #(
        .LIMIT (WC_CYC)
    ) u_wc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_DRAIN),
        .run   (state_q == ST_DRAIN),
        .done  (wc_done)
    );

    // Next-state logic.
    always_comb begin
        state_d  = state_q;
        step_hit = 1'b0;
        prot_set = 1'b0;
        prot_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_stb && hit_lead) begin
                    step_hit = 1'b1;
                    state_d  = ST_K1;
                end
            end
            ST_K1: begin
                if (wr_stb) begin
                    if (hit_second) begin
                        step_hit = 1'b1;
                        state_d  = ST_K2;
                    end else if (hit_lead) begin
                        step_hit = 1'b1;
                        state_d  = ST_K1;
                    end else begin
                        state_d  = ST_IDLE;
                    end
                end else if (gap_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_K2: begin
                if (wr_stb) begin
                    if (hit_lock) begin
                        step_hit = 1'b1;
                        prot_set = 1'b1;
                        state_d  = ST_OPEN;
                    end else if (hit_erase) begin
                        step_hit = 1'b1;
                        state_d  = ST_K3;
                    end else if (hit_lead) begin
                        step_hit = 1'b1;
                        state_d  = ST_K1;
                    end else begin
                        state_d  = ST_IDLE;
                    end
                end else if (gap_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_K3: begin
                if (wr_stb) begin
                    if (hit_lead) begin
                        step_hit = 1'b1;
                        state_d  = ST_K4;
                    end else begin
                        state_d  = ST_IDLE;
                    end
                end else if (gap_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_K4: begin
                if (wr_stb) begin
                    if (hit_second) begin
                        step_hit = 1'b1;
                        state_d  = ST_K5;
                    end else if (hit_lead) begin
                        step_hit = 1'b1;
                        state_d  = ST_K1;
                    end else begin
                        state_d  = ST_IDLE;
                    end
                end else if (gap_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_K5: begin
                if (wr_stb) begin
                    if (hit_clear) begin
                        step_hit = 1'b1;
                        state_d  = ST_DRAIN;
                    end else if (hit_lead) begin
                        step_hit = 1'b1;
                        state_d  = ST_K1;
                    end else begin
                        state_d  = ST_IDLE;
                    end
                end else if (gap_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_OPEN: begin
                if (load_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_DRAIN: begin
                if (wc_done) begin
                    prot_clr = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register and protection bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            prot_q  <= PROT_INIT;
        end else begin
            state_q <= state_d;
            if (prot_set) begin
                prot_q <= 1'b1;
            end else if (prot_clr) begin
                prot_q <= 1'b0;
            end
        end
    end

    // Output decode.
    always_comb begin
        wr_pass = 1'b0;
        cmd_eat = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                wr_pass = wr_stb;
            end
            ST_DRAIN: begin
                wr_pass = 1'b0;
            end
            default: begin
                if (hunting) begin
                    wr_pass = wr_stb && !prot_q;
                    cmd_eat = wr_stb && prot_q && step_hit;
                end
            end
        endcase
        prot_on = prot_q;
    end

endmodule

// File: rtl/wprot_seq_guard_chk.sv
module wprot_seq_guard_chk
    import wprot_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb,
    input logic       load_done,
    input logic       wr_pass,
    input logic       cmd_eat,
    input logic       prot_on,
    input seq_state_e state
);

    AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> (!wr_pass && !cmd_eat)); // R1

    AST_PASS_EAT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pass && cmd_eat)); // R3

    AST_EAT_NEEDS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_eat |-> prot_on); // R3

    AST_PROT_RISE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(wr_stb)); // R3

    AST_PROT_PASS_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pass && prot_on) |-> (state == ST_OPEN)); // R5

    AST_WINDOW_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && load_done) |=> (state == ST_IDLE)); // R4

    AST_PROT_FALL_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> ($past(state) == ST_DRAIN)); // R6

    AST_DRAIN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (!wr_pass && !cmd_eat)); // R6

endmodule

bind wprot_seq_guard wprot_seq_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .load_done (load_done),
    .wr_pass   (wr_pass),
    .cmd_eat   (cmd_eat),
    .prot_on   (prot_on),
    .state     (state_q)
);

// File: tb/wprot_seq_guard_bench.sv
module wprot_seq_guard_bench;

    localparam int GAP = 16;
    localparam int WC  = 24;
    localparam int NV  = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        load_done = 1'b0;
    logic        wr_pass;
    logic        cmd_eat;
    logic        prot_on;

    int total = 0;
    int bad = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    wprot_seq_guard #(
        .GAP_CYC   (GAP),
        .WC_CYC    (WC),
        .PROT_INIT (1'b0)
    ) u_wprot_seq_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load_done (load_done),
        .wr_pass   (wr_pass),
        .cmd_eat   (cmd_eat),
        .prot_on   (prot_on)
    );

    // Vector: stb, load, addr[15], data[8], exp pass, exp eat, exp prot after edge.
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 1'b0, 15'h0100, 8'h11, 3'b100},  // R2 plain write forwarded
        {1'b1, 1'b0, 15'h5555, 8'hAA, 3'b100},  // R2 command step forwarded
        {1'b1, 1'b0, 15'h2AAA, 8'h55, 3'b100},  // R2
        {1'b1, 1'b0, 15'h5555, 8'hA0, 3'b101},  // R3 R10 lock sets prot
        {1'b1, 1'b0, 15'h0200, 8'h22, 3'b101},  // R4 window write
        {1'b1, 1'b1, 15'h0201, 8'h23, 3'b101},  // R4 write with load_done
        {1'b1, 1'b0, 15'h0202, 8'h24, 3'b001},  // R5 blocked
        {1'b0, 1'b1, 15'h0000, 8'h00, 3'b001},  // R9 stray load_done
        {1'b1, 1'b0, 15'h0203, 8'h25, 3'b001},  // R9 still blocked
        {1'b1, 1'b0, 15'h5555, 8'hAA, 3'b011},  // R3 consumed
        {1'b1, 1'b0, 15'h2AAA, 8'h55, 3'b011},  // R3
        {1'b1, 1'b0, 15'h2AAA, 8'h55, 3'b001},  // R7 break
        {1'b1, 1'b0, 15'h2AAA, 8'h55, 3'b001},  // R7 matcher idle
        {1'b1, 1'b0, 15'h5555, 8'hAA, 3'b011},  // R7
        {1'b1, 1'b0, 15'h5555, 8'hAA, 3'b011},  // R7 restart at step one
        {1'b1, 1'b0, 15'h2AAA, 8'h55, 3'b011},  // R7
        {1'b1, 1'b0, 15'h5555, 8'hA0, 3'b011},  // R3 lock while protected
        {1'b1, 1'b0, 15'h7FFF, 8'h5A, 3'b101},  // R4 window write
        {1'b0, 1'b1, 15'h0000, 8'h00, 3'b001},  // R4 close
        {1'b1, 1'b0, 15'h5555, 8'hAA, 3'b011},  // R6
        {1'b1, 1'b0, 15'h2AAA, 8'h55, 3'b011},  // R6
        {1'b1, 1'b0, 15'h5555, 8'h80, 3'b011},  // R6 R10 erase step
        {1'b1, 1'b0, 15'h5555, 8'hAA, 3'b011},  // R6
        {1'b1, 1'b0, 15'h2AAA, 8'h55, 3'b011},  // R6
        {1'b1, 1'b0, 15'h5555, 8'h20, 3'b011}   // R6 release starts
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Drive at the falling edge, check combinational outputs, then step one edge.
    task automatic cyc(input logic stb, input logic ld, input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb    = stb;
        load_done = ld;
        wr_addr   = a;
        wr_data   = d;
        #2;
    endtask

    task automatic edge_step();
        @(posedge clk);
        #1;
        wr_stb    = 1'b0;
        load_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 prot after reset", prot_on, 1'b0);
        check("R1 pass idle", wr_pass, 1'b0);
        check("R1 eat idle", cmd_eat, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][27], VEC[i][26], VEC[i][25:11], VEC[i][10:3]);
            check($sformatf("vec%0d pass", i), wr_pass, VEC[i][2]);
            check($sformatf("vec%0d eat", i), cmd_eat, VEC[i][1]);
            edge_step();
            check($sformatf("vec%0d prot", i), prot_on, VEC[i][0]);
        end

        // R6: release interval; first cycle carries a dropped write.
        cyc(1'b1, 1'b0, 15'h0300, 8'h31);
        check("R6 drop pass", wr_pass, 1'b0);
        check("R6 drop eat", cmd_eat, 1'b0);
        edge_step();
        for (int k = 2; k < WC; k++) begin
            cyc(1'b0, 1'b0, 15'h0, 8'h0);
            edge_step();
        end
        check("R6 prot held", prot_on, 1'b1);
        cyc(1'b0, 1'b0, 15'h0, 8'h0);
        edge_step();
        check("R6 prot cleared", prot_on, 1'b0);

        cyc(1'b1, 1'b0, 15'h0400, 8'h41);
        check("R2 pass after release", wr_pass, 1'b1);
        edge_step();

        // R8: gap too long, the lock step is judged from idle.
        cyc(1'b1, 1'b0, 15'h5555, 8'hAA); edge_step();
        cyc(1'b1, 1'b0, 15'h2AAA, 8'h55); edge_step();
        for (int k = 0; k < GAP; k++) begin
            cyc(1'b0, 1'b0, 15'h0, 8'h0);
            edge_step();
        end
        cyc(1'b1, 1'b0, 15'h5555, 8'hA0);
        check("R8 late step pass", wr_pass, 1'b1);
        edge_step();
        check("R8 late step no lock", prot_on, 1'b0);

        // R8: step exactly at the gap limit still counts.
        cyc(1'b1, 1'b0, 15'h5555, 8'hAA); edge_step();
        cyc(1'b1, 1'b0, 15'h2AAA, 8'h55); edge_step();
        for (int k = 0; k < GAP - 1; k++) begin
            cyc(1'b0, 1'b0, 15'h0, 8'h0);
            edge_step();
        end
        cyc(1'b1, 1'b0, 15'h5555, 8'hA0);
        edge_step();
        check("R8 step at limit locks", prot_on, 1'b1);
        cyc(1'b1, 1'b0, 15'h0500, 8'h51);
        check("R4 window after timed lock", wr_pass, 1'b1);
        edge_step();
        cyc(1'b0, 1'b1, 15'h0, 8'h0); edge_step();
        cyc(1'b1, 1'b0, 15'h0501, 8'h52);
        check("R5 blocked after close", wr_pass, 1'b0);
        check("R5 not eaten", cmd_eat, 1'b0);
        edge_step();

        finish_run();
    end

endmodule